// File: doc/BRIEF.md
# Round-Robin Receive Frame Mover

This block drains several per-port receive FIFOs into one shared frame buffer memory that is 64 bits wide. The ports take turns in round-robin order. A port whose FIFO is empty, or which still has an unserved switch request, is passed over. Each turn moves exactly one word. The last word of a frame may be partly filled, and that partial fill is expressed through the byte enables.

Every frame is written into a buffer chosen by a handle. The handle comes from an allocator that always has one ready. The word address is the handle followed by the word offset within the frame, and the offset starts again at zero for every new frame. While a frame streams in, the block keeps a copy of its first eight words.

When the last word arrives flagged good, the port holds a switch request carrying:
- the port number
- the handle
- the byte length
- the captured header words

A second round-robin arbiter presents one pending request at a time and holds it until the downstream side acknowledges it. A frame whose last word is flagged bad raises no request. Its handle is handed back on a return strobe instead.

Top module: `rxdma_mover`

State machines:
- **Per-port context.** States P_IDLE, P_FILL and P_WAIT. Transitions:
  - START: P_IDLE to P_FILL, on a first word that is not last.
  - SOLO_GOOD: P_IDLE to P_WAIT, on a one-word good frame.
  - SOLO_BAD: P_IDLE to P_IDLE, on a one-word bad frame.
  - END_GOOD: P_FILL to P_WAIT, on a good last word.
  - END_BAD: P_FILL to P_IDLE, on a bad last word.
  - GRANTED: P_WAIT to P_IDLE, on acknowledge.
- **Mover.** States MV_IDLE and MV_XFER. TURN enters MV_XFER whenever some port is served. NO_TURN enters MV_IDLE when no port is served.
- **Request arbiter.** States SA_IDLE and SA_HOLD. PICK goes from SA_IDLE to SA_HOLD when some request is pending. RELEASE goes from SA_HOLD to SA_IDLE on acknowledge.

## Requirements
- R1: Each turn pops one word from the served port's FIFO and writes it to memory one cycle later. The memory address is {handle, word offset}, with the word offset 5 bits wide by default and 0 for the first word of every frame.
- R2: The written data equals the popped word. `mem_be` bit i enables byte i (bits 8i+7:8i). It is all ones for a word that is not last. For a last word with byte count `n` (1 to 8), only bits 0 to n-1 are set.
- R3: A switch request for a frame appears only after that frame's last word, flagged good (`fifo_eof`=1, `fifo_err`=0), has been written to memory.
- R4: A request carries the port, the frame's handle, and the length in bytes (8 × (words − 1) + n). `sreq_hdr` bits 64w+63:64w hold frame word w for w = 0 to 7. Header words past the end of the frame read zero.
- R5: At most one port is served per cycle, and only a port with `fifo_valid` high. Service rotates round-robin, starting at port 0 after reset and continuing after the last served port. Ports with nothing to move are skipped.
- R6: `hdl_take` pulses in exactly the cycle in which a frame's first word is popped. The value on `hdl_in` in that cycle becomes the frame's handle.
- R7: A frame whose last word is flagged bad (`fifo_err`=1) produces no switch request. In this case `hdl_free_valid` pulses for one cycle, together with that last word's memory write, and `hdl_free_id` carries the frame's handle.
- R8: Only one request is presented at a time. It stays valid, with port, handle, length and header unchanged, until the cycle in which `sreq_ack` is high. Request selection is round-robin, starting at port 0 after reset and continuing after the last acknowledged port.
- R9: A port whose request has not yet been acknowledged is not served again.
- R10: During reset, `mem_we`, `sreq_valid`, `hdl_free_valid` and `hdl_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_valid | input | N_PORTS | FIFO head word present, one bit per port |
| fifo_data | input | N_PORTS*64 | FIFO head word, port p in bits 64p+63:64p |
| fifo_eof | input | N_PORTS | Head word is the last of its frame |
| fifo_err | input | N_PORTS | Last word ends a bad frame |
| fifo_nb | input | N_PORTS*4 | Valid byte count of a last word (1 to 8) |
| fifo_rd | output | N_PORTS | Pop strobe, at most one bit set |
| hdl_in | input | HDL_W | Next free buffer handle |
| hdl_take | output | 1 | The offered handle is consumed |
| hdl_free_valid | output | 1 | Handle return strobe for a bad frame |
| hdl_free_id | output | HDL_W | Returned handle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | HDL_W+5 | Memory word address |
| mem_data | output | 64 | Memory write data |
| mem_be | output | 8 | Memory byte enables |
| sreq_valid | output | 1 | Switch request presented |
| sreq_port | output | 2 | Requesting port |
| sreq_handle | output | HDL_W | Frame handle |
| sreq_len | output | 9 | Frame length in bytes |
| sreq_hdr | output | 512 | First eight frame words |
| sreq_ack | input | 1 | Downstream accepts the request |

## Verification
Some internal faults show up one cycle after the faulty turn, as a wrong memory write:
- a word offset that is not cleared on a new frame
- a stale handle
- a turn pointer that fails to rotate

Each write is compared with the word the bench expects from its FIFO model. A port context stuck in the wrong state shows up in one of two ways. It may issue a request for a bad frame, or a request before its last word is stored. Otherwise the port goes quiet while its FIFO is non-empty, and is read again while its request is pending. A corrupted header or length register is seen on the first cycle the request is presented. The directed phases pin down the rotation order at both arbiters and the hold behaviour while acknowledge is withheld. The random phase mixes gaps, frame sizes, bad endings and acknowledge delays.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_FILL = 2'd1,
        P_WAIT = 2'd2
    } port_st_t;

    typedef enum logic {
        MV_IDLE = 1'b0,
        MV_XFER = 1'b1
    } mv_st_t;

    typedef enum logic {
        SA_IDLE = 1'b0,
        SA_HOLD = 1'b1
    } sa_st_t;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    // First requester at or after ptr, wrapping around.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            int c;
            c = (int'(ptr) + i) % N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
    end
endmodule

// File: rtl/rxdma_port_ctx.sv
module rxdma_port_ctx
    import rxdma_pkg::*;
#(
    parameter int DW        = 64,
    parameter int HDL_W     = 4,
    parameter int BUF_LG    = 5,
    parameter int HDR_WORDS = 8,
    parameter int NB_W      = 4,
    parameter int LEN_W     = 9,
    localparam int ADDR_W   = HDL_W + BUF_LG,
    localparam int BE_W     = DW / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    turn,
    input  logic [DW-1:0]           in_data,
    input  logic                    in_eof,
    input  logic                    in_err,
    input  logic [NB_W-1:0]         in_nb,
    input  logic [HDL_W-1:0]        new_hdl,
    input  logic                    ack,
    output logic                    busy,
    output logic                    take,
    output logic [HDL_W-1:0]        hdl_use,
    output logic [HDL_W-1:0]        hdl_held,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [LEN_W-1:0]        req_len,
    output logic [HDR_WORDS*DW-1:0] req_hdr
);
    port_st_t st_q, st_d;
    logic [BUF_LG-1:0]                ofs_q;
    logic [BUF_LG-1:0]                cur_ofs;
    logic [HDL_W-1:0]                 hdl_q;
    logic [LEN_W-1:0]                 len_q;
    logic [HDR_WORDS-1:0][DW-1:0]     hdr_q;
    logic                             fresh;

    assign fresh   = (st_q == P_IDLE);
    assign cur_ofs = fresh ? '0 : ofs_q;
    assign hdl_use = fresh ? new_hdl : hdl_q;
    assign wr_addr = {hdl_use, cur_ofs};
    assign take    = turn && fresh;
    assign busy    = (st_q == P_WAIT);
    assign hdl_held = hdl_q;
    assign req_len = len_q;
    assign req_hdr = hdr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= P_IDLE;
        else        st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            P_IDLE, P_FILL: begin
                if (turn) begin
                    if (!in_eof)     st_d = P_FILL;   // START / stay
                    else if (in_err) st_d = P_IDLE;   // SOLO_BAD / END_BAD
                    else             st_d = P_WAIT;   // SOLO_GOOD / END_GOOD
                end
            end
            P_WAIT: if (ack) st_d = P_IDLE;           // GRANTED
            default: st_d = P_IDLE;
        endcase
    end

    // Frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
            hdl_q <= '0;
            len_q <= '0;
        end else if (turn) begin
            ofs_q <= cur_ofs + 1'b1;
            hdl_q <= hdl_use;
            if (in_eof)
                len_q <= LEN_W'(cur_ofs) * LEN_W'(BE_W) + LEN_W'(in_nb);
        end
    end

    // Header capture: words that a short frame never reaches are cleared at its start.
    for (genvar w = 0; w < HDR_WORDS; w++) begin : g_hdr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hdr_q[w] <= '0;
            end else if (turn) begin
                if (cur_ofs == BUF_LG'(w)) hdr_q[w] <= in_data;
                else if (fresh)            hdr_q[w] <= '0;
            end
        end
    end

    // R9: no turn is granted to a port holding an unserved request
    a_r9_no_turn_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        turn |-> (st_q != P_WAIT));

    // R3: a pending request only begins after a good last word was taken
    a_r3_wait_after_good_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(turn && in_eof && !in_err));

    // R8: request data held while waiting
    a_r8_ctx_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> ($stable(req_len) && $stable(hdl_held)));
endmodule

// File: rtl/rxdma_sreq_arb.sv
module rxdma_sreq_arb
    import rxdma_pkg::*;
#(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int HDL_W = 4,
    parameter int LEN_W = 9,
    parameter int HW    = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            pend,
    input  logic [N-1:0][HDL_W-1:0] hdl,
    input  logic [N-1:0][LEN_W-1:0] len,
    input  logic [N-1:0][HW-1:0]    hdr,
    input  logic                    ack,
    output logic                    valid,
    output logic [IW-1:0]           port,
    output logic [HDL_W-1:0]        handle,
    output logic [LEN_W-1:0]        len_o,
    output logic [HW-1:0]           hdr_o,
    output logic                    done
);
    sa_st_t st_q, st_d;
    logic [IW-1:0] gnt_q, ptr_q;
    logic          any;
    logic [IW-1:0] idx;

    rr_pick #(.N(N), .IW(IW)) u_pick (
        .req (pend),
        .ptr (ptr_q),
        .any (any),
        .idx (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SA_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SA_IDLE: if (any) st_d = SA_HOLD;   // PICK
            SA_HOLD: if (ack) st_d = SA_IDLE;   // RELEASE
            default: st_d = SA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_q <= '0;
            ptr_q <= '0;
        end else begin
            if (st_q == SA_IDLE && any) gnt_q <= idx;
            if (st_q == SA_HOLD && ack)
                ptr_q <= (int'(gnt_q) == N - 1) ? '0 : gnt_q + 1'b1;
        end
    end

    assign valid  = (st_q == SA_HOLD);
    assign port   = gnt_q;
    assign handle = hdl[gnt_q];
    assign len_o  = len[gnt_q];
    assign hdr_o  = hdr[gnt_q];
    assign done   = valid && ack;

    // R8: presented request is held until acknowledged
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> (valid && $stable(port) && $stable(hdr_o) && $stable(handle)));

    // R3: only a port with a completed good frame is presented
    a_r3_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pend[port]);
endmodule

// File: rtl/rxdma_mover.sv
module rxdma_mover
    import rxdma_pkg::*;
#(
    parameter int N_PORTS   = 4,
    parameter int DW        = 64,
    parameter int HDL_W     = 4,
    parameter int BUF_LG    = 5,
    parameter int HDR_WORDS = 8,
    localparam int BE_W     = DW / 8,
    localparam int NB_W     = $clog2(BE_W) + 1,
    localparam int ADDR_W   = HDL_W + BUF_LG,
    localparam int LEN_W    = BUF_LG + $clog2(BE_W) + 1,
    localparam int PIDX_W   = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int HW       = HDR_WORDS * DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        fifo_valid,
    input  logic [N_PORTS*DW-1:0]     fifo_data,
    input  logic [N_PORTS-1:0]        fifo_eof,
    input  logic [N_PORTS-1:0]        fifo_err,
    input  logic [N_PORTS*NB_W-1:0]   fifo_nb,
    output logic [N_PORTS-1:0]        fifo_rd,
    input  logic [HDL_W-1:0]          hdl_in,
    output logic                      hdl_take,
    output logic                      hdl_free_valid,
    output logic [HDL_W-1:0]          hdl_free_id,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DW-1:0]             mem_data,
    output logic [BE_W-1:0]           mem_be,
    output logic                      sreq_valid,
    output logic [PIDX_W-1:0]         sreq_port,
    output logic [HDL_W-1:0]          sreq_handle,
    output logic [LEN_W-1:0]          sreq_len,
    output logic [HW-1:0]             sreq_hdr,
    input  logic                      sreq_ack
);
    logic [N_PORTS-1:0]              p_busy, p_take, p_ack;
    logic [N_PORTS-1:0][HDL_W-1:0]   p_hdl_use, p_hdl_held;
    logic [N_PORTS-1:0][ADDR_W-1:0]  p_addr;
    logic [N_PORTS-1:0][LEN_W-1:0]   p_len;
    logic [N_PORTS-1:0][HW-1:0]      p_hdr;
    logic [N_PORTS-1:0]              eligible;
    logic                            mv_any;
    logic [PIDX_W-1:0]               mv_idx, mv_ptr;
    mv_st_t                          mv_st_q, mv_st_d;
    logic [DW-1:0]                   sel_data;
    logic                            sel_eof, sel_err;
    logic [NB_W-1:0]                 sel_nb;
    logic [BE_W-1:0]                 sel_be;
    logic                            sa_done;

    // Turn selection
    assign eligible = fifo_valid & ~p_busy;

    rr_pick #(.N(N_PORTS), .IW(PIDX_W)) u_mv_pick (
        .req (eligible),
        .ptr (mv_ptr),
        .any (mv_any),
        .idx (mv_idx)
    );

    always_comb begin
        fifo_rd = '0;
        if (mv_any) fifo_rd[mv_idx] = 1'b1;
    end

    assign sel_data = fifo_data[mv_idx*DW +: DW];
    assign sel_eof  = fifo_eof[mv_idx];
    assign sel_err  = fifo_err[mv_idx];
    assign sel_nb   = fifo_nb[mv_idx*NB_W +: NB_W];

    always_comb begin
        for (int b = 0; b < BE_W; b++)
            sel_be[b] = !sel_eof || (NB_W'(b) < sel_nb);
    end

    // Per-port frame contexts
    for (genvar gp = 0; gp < N_PORTS; gp++) begin : g_port
        assign p_ack[gp] = sa_done && (sreq_port == PIDX_W'(gp));

        rxdma_port_ctx #(
            .DW        (DW),
            .HDL_W     (HDL_W),
            .BUF_LG    (BUF_LG),
            .HDR_WORDS (HDR_WORDS),
            .NB_W      (NB_W),
            .LEN_W     (LEN_W)
        ) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .turn     (fifo_rd[gp]),
            .in_data  (fifo_data[gp*DW +: DW]),
            .in_eof   (fifo_eof[gp]),
            .in_err   (fifo_err[gp]),
            .in_nb    (fifo_nb[gp*NB_W +: NB_W]),
            .new_hdl  (hdl_in),
            .ack      (p_ack[gp]),
            .busy     (p_busy[gp]),
            .take     (p_take[gp]),
            .hdl_use  (p_hdl_use[gp]),
            .hdl_held (p_hdl_held[gp]),
            .wr_addr  (p_addr[gp]),
            .req_len  (p_len[gp]),
            .req_hdr  (p_hdr[gp])
        );
    end

    assign hdl_take = |p_take;

    // Mover state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_st_q <= MV_IDLE;
        else        mv_st_q <= mv_st_d;
    end

    always_comb begin
        mv_st_d = mv_st_q;
        unique case (mv_st_q)
            MV_IDLE: mv_st_d = mv_any ? MV_XFER : MV_IDLE;   // TURN / NO_TURN
            MV_XFER: mv_st_d = mv_any ? MV_XFER : MV_IDLE;   // TURN / NO_TURN
            default: mv_st_d = MV_IDLE;
        endcase
    end

    // Mover outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr       <= '0;
            mem_data       <= '0;
            mem_be         <= '0;
            mv_ptr         <= '0;
            hdl_free_valid <= 1'b0;
            hdl_free_id    <= '0;
        end else begin
            hdl_free_valid <= mv_any && sel_eof && sel_err;
            if (mv_any) begin
                mem_addr    <= p_addr[mv_idx];
                mem_data    <= sel_data;
                mem_be      <= sel_be;
                hdl_free_id <= p_hdl_use[mv_idx];
                mv_ptr      <= (int'(mv_idx) == N_PORTS - 1) ? '0 : mv_idx + 1'b1;
            end
        end
    end

    assign mem_we = (mv_st_q == MV_XFER);

    // Switch request arbitration
    rxdma_sreq_arb #(
        .N     (N_PORTS),
        .IW    (PIDX_W),
        .HDL_W (HDL_W),
        .LEN_W (LEN_W),
        .HW    (HW)
    ) u_sreq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (p_busy),
        .hdl    (p_hdl_held),
        .len    (p_len),
        .hdr    (p_hdr),
        .ack    (sreq_ack),
        .valid  (sreq_valid),
        .port   (sreq_port),
        .handle (sreq_handle),
        .len_o  (sreq_len),
        .hdr_o  (sreq_hdr),
        .done   (sa_done)
    );

    // R5: one turn per cycle, only to a port with data
    a_r5_one_turn: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_rd));
    a_r5_turn_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd & ~fifo_valid) == '0);

    // R6: a handle is consumed only during a turn
    a_r6_take_on_turn: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_take |-> (|fifo_rd));

    // R7: handle return coincides with the frame's last write
    a_r7_free_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        hdl_free_valid |-> mem_we);

    // R1: every turn yields a write on the next cycle
    a_r1_turn_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_rd) |=> mem_we);
endmodule

// File: tb/rxdma_mover_tb_top.sv
module rxdma_mover_tb_top;
    localparam int N  = 4;
    localparam int QD = 256;
    localparam int FD = 48;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic [N-1:0]    fifo_valid, fifo_eof, fifo_err, fifo_rd;
    logic [N*64-1:0] fifo_data;
    logic [N*4-1:0]  fifo_nb;
    logic [3:0]      hdl_in, hdl_free_id, sreq_handle;
    logic            hdl_take, hdl_free_valid, mem_we, sreq_valid, sreq_ack;
    logic [8:0]      mem_addr, sreq_len;
    logic [63:0]     mem_data;
    logic [7:0]      mem_be;
    logic [1:0]      sreq_port;
    logic [511:0]    sreq_hdr;

    rxdma_mover dut_i (.*);

    // Bench FIFO model and frame records
    logic [63:0] qd [N][QD];
    logic        qe [N][QD];
    logic        qr [N][QD];
    logic [3:0]  qn [N][QD];
    int          head [N], tail [N];
    int          fr_start [N][FD], fr_words [N][FD], fr_cnt [N];
    logic        fr_err [N][FD], fr_done [N][FD];
    logic [3:0]  fr_nb [N][FD], fr_h [N][FD];
    int          rd_fr [N], wpos [N], chk_fr [N];
    bit          waiting [N];

    int n_chk = 0, n_fail = 0, cycles = 0;
    int ack_mode = 0;
    bit gate_rand = 0;
    bit sr_seen = 0;
    logic [3:0] hdl_ctr = 4'd0;
    bit pw_v = 0, pw_last = 0;
    int pw_p = 0, pw_f = 0;
    logic [8:0] pw_addr;
    logic [63:0] pw_data;
    logic [7:0] pw_be;
    bit ef_v = 0;
    logic [3:0] ef_id;
    int wlog [64]; int wlog_n = 0;
    int glog [64]; int glog_n = 0;

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_be(input logic eof, input logic [3:0] nb);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) m[b] = !eof || (b < int'(nb));
        return m;
    endfunction

    function automatic logic [511:0] exp_hdr(input int p, input int f);
        logic [511:0] h = '0;
        for (int w = 0; w < 8; w++)
            if (w < fr_words[p][f]) h[w*64 +: 64] = qd[p][fr_start[p][f] + w];
        return h;
    endfunction

    function automatic logic [8:0] exp_len(input int p, input int f);
        return 9'((fr_words[p][f] - 1) * 8 + int'(fr_nb[p][f]));
    endfunction

    task automatic add_frame(input int p, input int words, input logic [3:0] nb, input logic err);
        fr_start[p][fr_cnt[p]] = tail[p];
        fr_words[p][fr_cnt[p]] = words;
        fr_nb[p][fr_cnt[p]]    = nb;
        fr_err[p][fr_cnt[p]]   = err;
        fr_done[p][fr_cnt[p]]  = 1'b0;
        fr_cnt[p]++;
        for (int i = 0; i < words; i++) begin
            qd[p][tail[p]] = {$urandom, $urandom};
            qe[p][tail[p]] = (i == words - 1);
            qr[p][tail[p]] = err && (i == words - 1);
            qn[p][tail[p]] = (i == words - 1) ? nb : 4'd8;
            tail[p]++;
        end
    endtask

    task automatic cycle();
        int p, f;
        bit exp_take;
        @(negedge clk);
        cycles++;
        // R1, R2: write from the previous turn
        if (pw_v) begin
            chk(mem_we && mem_addr == pw_addr && mem_data == pw_data && mem_be == pw_be,
                "R1/R2 memory write", {mem_we, mem_addr, mem_be, mem_data}, {1'b1, pw_addr, pw_be, pw_data});
            if (pw_last) fr_done[pw_p][pw_f] = 1'b1;
            if (wlog_n < 64) begin wlog[wlog_n] = pw_p; wlog_n++; end
        end else begin
            chk(!mem_we, "R1 no write without turn", mem_we, 0);
        end
        // R7: handle return
        chk(hdl_free_valid == ef_v && (!ef_v || hdl_free_id == ef_id),
            "R7 handle return", {hdl_free_valid, hdl_free_id}, {ef_v, ef_id});
        // R3, R4: newly presented request
        if (sreq_valid && !sr_seen) begin
            p = int'(sreq_port);
            while (chk_fr[p] < fr_cnt[p] && fr_err[p][chk_fr[p]]) chk_fr[p]++;
            f = chk_fr[p];
            if (f >= fr_cnt[p]) begin
                chk(0, "R7 request for no good frame", sreq_port, 0);
            end else begin
                chk(fr_done[p][f], "R3 request after last word stored", fr_done[p][f], 1);
                chk(sreq_hdr == exp_hdr(p, f), "R4 header words", sreq_hdr, exp_hdr(p, f));
                chk(sreq_len == exp_len(p, f) && sreq_handle == fr_h[p][f], "R4 length and handle",
                    {sreq_len, sreq_handle}, {exp_len(p, f), fr_h[p][f]});
            end
            sr_seen = 1;
            if (glog_n < 64) begin glog[glog_n] = p; glog_n++; end
        end
        // Acknowledge
        case (ack_mode)
            0: sreq_ack = 1'b0;
            1: sreq_ack = 1'b1;
            default: sreq_ack = ($urandom % 2) == 0;
        endcase
        if (sreq_ack && sreq_valid) begin
            sr_seen = 0;
            p = int'(sreq_port);
            if (chk_fr[p] < fr_cnt[p]) chk_fr[p]++;
        end
        // FIFO heads
        for (int q = 0; q < N; q++) begin
            bit av;
            av = head[q] < tail[q];
            fifo_valid[q] = av && (!gate_rand || ($urandom % 10) < 7);
            fifo_data[q*64 +: 64] = av ? qd[q][head[q]] : 64'd0;
            fifo_eof[q] = av ? qe[q][head[q]] : 1'b0;
            fifo_err[q] = av ? qr[q][head[q]] : 1'b0;
            fifo_nb[q*4 +: 4] = av ? qn[q][head[q]] : 4'd0;
        end
        hdl_in = hdl_ctr;
        #1;
        pw_v = 0; ef_v = 0; exp_take = 0;
        for (int q = 0; q < N; q++) begin
            if (fifo_rd[q]) begin
                chk(!waiting[q], "R9 no turn while request pending", fifo_rd, 0);
                chk(fifo_valid[q], "R5 turn only with data", fifo_valid, fifo_rd);
                if (wpos[q] == 0) begin
                    exp_take = 1;
                    fr_h[q][rd_fr[q]] = hdl_in;
                    hdl_ctr = hdl_ctr + 4'd1;
                end
                pw_v = 1; pw_p = q; pw_f = rd_fr[q];
                pw_addr = {fr_h[q][rd_fr[q]], 5'(wpos[q])};
                pw_data = qd[q][head[q]];
                pw_be = exp_be(qe[q][head[q]], qn[q][head[q]]);
                pw_last = qe[q][head[q]];
                if (qe[q][head[q]]) begin
                    if (qr[q][head[q]]) begin ef_v = 1; ef_id = fr_h[q][rd_fr[q]]; end
                    else waiting[q] = 1;
                    wpos[q] = 0;
                    rd_fr[q]++;
                end else begin
                    wpos[q]++;
                end
                head[q]++;
            end
        end
        chk(hdl_take == exp_take, "R6 handle take strobe", hdl_take, exp_take);
        if (sreq_ack && sreq_valid) waiting[int'(sreq_port)] = 0;
    endtask

    function automatic bit drained();
        for (int q = 0; q < N; q++) begin
            if (head[q] != tail[q] || waiting[q]) return 0;
        end
        return !sreq_valid;
    endfunction

    initial begin
        for (int q = 0; q < N; q++) begin
            head[q] = 0; tail[q] = 0; fr_cnt[q] = 0; rd_fr[q] = 0;
            wpos[q] = 0; chk_fr[q] = 0; waiting[q] = 0;
        end
        void'($urandom(32'd1234));
        rst_n = 1'b0; fifo_valid = '0; fifo_data = '0; fifo_eof = '0;
        fifo_err = '0; fifo_nb = '0; hdl_in = '0; sreq_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!mem_we && !sreq_valid && !hdl_free_valid && !hdl_take, "R10 reset outputs",
            {mem_we, sreq_valid, hdl_free_valid, hdl_take}, 0);
        rst_n = 1'b1;

        // Directed: all ports, two-word frames, acknowledge withheld
        for (int q = 0; q < N; q++) add_frame(q, 2, 4'd8, 1'b0);
        ack_mode = 0; wlog_n = 0; glog_n = 0;
        repeat (14) cycle();
        chk(wlog_n == 8 && wlog[0] == 0 && wlog[1] == 1 && wlog[2] == 2 && wlog[3] == 3 &&
            wlog[4] == 0 && wlog[5] == 1 && wlog[6] == 2 && wlog[7] == 3,
            "R5 rotation order", {wlog[0][1:0], wlog[1][1:0], wlog[2][1:0], wlog[3][1:0]}, 16'h0123);
        chk(sreq_valid && sreq_port == 2'd0, "R8 first request held", {sreq_valid, sreq_port}, 3'b100);
        ack_mode = 1;
        repeat (12) cycle();
        chk(glog_n == 4 && glog[0] == 0 && glog[1] == 1 && glog[2] == 2 && glog[3] == 3,
            "R8 request rotation", glog_n, 4);

        // Directed: only ports 1 and 3 have data, partial last words
        add_frame(1, 3, 4'd3, 1'b0);
        add_frame(3, 2, 4'd5, 1'b0);
        wlog_n = 0;
        repeat (12) cycle();
        chk(wlog_n == 5 && wlog[0] == 1 && wlog[1] == 3 && wlog[2] == 1 && wlog[3] == 3 && wlog[4] == 1,
            "R5 skip empty ports", wlog_n, 5);

        // Directed: one-word bad frame, then a long good frame
        glog_n = 0;
        add_frame(2, 1, 4'd1, 1'b1);
        repeat (8) cycle();
        chk(glog_n == 0 && !sreq_valid, "R7 no request for bad frame", glog_n, 0);
        add_frame(0, 11, 4'd2, 1'b0);
        add_frame(0, 1, 4'd8, 1'b0);
        repeat (30) cycle();

        // Random phase
        gate_rand = 1; ack_mode = 2;
        for (int q = 0; q < N; q++)
            for (int k = 0; k < 15; k++)
                add_frame(q, 1 + int'($urandom % 12), 4'(1 + $urandom % 8), ($urandom % 5) == 0);
        begin
            int guard = 0;
            while (!drained() && guard < 50000) begin
                cycle();
                guard++;
            end
            if (guard >= 50000) chk(0, "R5 watchdog expired", guard, 0);
        end
        repeat (4) cycle();
        for (int q = 0; q < N; q++)
            chk(head[q] == tail[q], "R9 every port drained", head[q], tail[q]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule